// File: doc/BRIEF.md
# Two-Port Memory with Flag-Space Decode

This block is a synchronous two-port memory of 4096 words of 8 bits with a second, small address space for hardware lock flags. Each port, left and right, has its own address, write data, chip enable, flag-space select, output enable and read/write strobe. On every clock edge each port decodes its four control inputs into one action: memory read, memory write, flag read, flag write, idle, or an illegal combination. The two ports never wait on each other.

The flag space is held in a separate lock unit outside this block. A flag write is passed to that unit in the same cycle on a request strobe, together with the flag index (the low three address bits) and the value (write data bit 0). For a flag read, the block samples the one-bit flag value returned by the unit and spreads it over all eight output bits. Memory and flag read data appear on the port's data output one cycle after the edge that sampled the request, together with a data-valid strobe. When both selects of a port are active at once, no access takes place and a sticky per-port error flag is raised. The reset is asynchronous and active low, and its release must already be synchronised to the clock.

Top module: `dpram_semspace`

## Requirements
- R1: The memory holds 4096 words of 8 bits addressed by 12 bits per port; a word written at one edge is returned by a later memory read of the same address from either port.
- R2: Both ports act in the same cycle with no stall: two reads, two writes, or a read and a write on the two ports all complete in that cycle.
- R3: With chip enable high and flag select high the port is idle: the next cycle shows data-valid low and data output 0, and nothing is written.
- R4: Chip enable low, flag select high, read/write high and output enable low is a memory read; in the next cycle data-valid is 1 and the output holds the word stored before that edge, even if the other port writes the same address at that edge.
- R5: Chip enable low, flag select high and read/write low writes the write data into memory at that edge whatever the output enable; the next cycle shows data-valid low.
- R6: Chip enable high, flag select low and read/write low is a flag write: in that same cycle the flag write strobe is 1, the flag index equals address bits 2:0 and the flag value equals write data bit 0; memory is not written.
- R7: Chip enable high, flag select low, read/write high and output enable low is a flag read: in the next cycle data-valid is 1 and all 8 output bits equal the flag value returned by the lock unit at that edge.
- R8: With output enable high and read/write high, the next cycle shows data-valid low and data output 0, whichever select is active.
- R9: Chip enable low and flag select low together is illegal: there is no memory write and no flag write strobe, data-valid is low in the next cycle, and the port's error flag becomes 1 at that edge and stays 1 until reset; later legal accesses on the port still work.
- R10: When both ports write the same address at the same edge, the left port's data is stored.
- R11: While reset is low, both error flags, both data-valid strobes and both data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lf_addr | input | 12 | Left port address |
| lf_wdata | input | 8 | Left port write data |
| lf_ce_n | input | 1 | Left port memory chip enable, active low |
| lf_flag_sel_n | input | 1 | Left port flag-space select, active low |
| lf_oe_n | input | 1 | Left port output enable, active low |
| lf_rd | input | 1 | Left port read/write strobe, 1 = read, 0 = write |
| lf_rdata | output | 8 | Left port read data, 0 when not valid |
| lf_rdata_en | output | 1 | Left port read data valid |
| lf_err | output | 1 | Left port sticky illegal-select flag |
| lf_flag_we | output | 1 | Left port flag write strobe to the lock unit |
| lf_flag_idx | output | 3 | Left port flag index to the lock unit |
| lf_flag_wbit | output | 1 | Left port flag write value |
| lf_flag_val | input | 1 | Flag value returned by the lock unit for the left port |
| rt_addr | input | 12 | Right port address |
| rt_wdata | input | 8 | Right port write data |
| rt_ce_n | input | 1 | Right port memory chip enable, active low |
| rt_flag_sel_n | input | 1 | Right port flag-space select, active low |
| rt_oe_n | input | 1 | Right port output enable, active low |
| rt_rd | input | 1 | Right port read/write strobe, 1 = read, 0 = write |
| rt_rdata | output | 8 | Right port read data, 0 when not valid |
| rt_rdata_en | output | 1 | Right port read data valid |
| rt_err | output | 1 | Right port sticky illegal-select flag |
| rt_flag_we | output | 1 | Right port flag write strobe to the lock unit |
| rt_flag_idx | output | 3 | Right port flag index to the lock unit |
| rt_flag_wbit | output | 1 | Right port flag write value |
| rt_flag_val | input | 1 | Flag value returned by the lock unit for the right port |

## Verification
The two functions that meet in one cycle are a write on one port and a read or write of the same memory word on the other. The bench drives a left write and a right read of one address at the same edge and expects the old word on the right port, then drives two writes of one address and expects the left data on the following reads. A behavioural model in the bench, holding the memory in an associative array, predicts every output each cycle, and an illegal select on one port is placed next to legal traffic on the other to show the ports stay independent.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_QUIET  = 3'd1,
    ACT_MEM_RD = 3'd2,
    ACT_MEM_WR = 3'd3,
    ACT_FLG_RD = 3'd4,
    ACT_FLG_WR = 3'd5,
    ACT_BAD    = 3'd6
  } port_act_t;

  function automatic port_act_t decode_act(input logic ce_n, input logic sel_n,
                                           input logic rd, input logic oe_n);
    port_act_t a;
    unique case ({ce_n, sel_n})
      2'b00:   a = ACT_BAD;
      2'b11:   a = ACT_IDLE;
      2'b01:   a = !rd ? ACT_MEM_WR : (!oe_n ? ACT_MEM_RD : ACT_QUIET);
      default: a = !rd ? ACT_FLG_WR : (!oe_n ? ACT_FLG_RD : ACT_QUIET);
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dpsem_port_ctrl.sv
module dpsem_port_ctrl
  import dpsem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      sel_n,
  input  logic      rd,
  input  logic      oe_n,
  output port_act_t act,
  output logic      err_q
);

  logic err_d;

  always_comb begin
    act   = decode_act(ce_n, sel_n, rd, oe_n);
    err_d = err_q | (act == ACT_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/dpsem_mem_core.sv
module dpsem_mem_core #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NPORT  = 2
) (
  input  logic                          clk,
  input  logic [NPORT-1:0]              we,
  input  logic [NPORT-1:0]              re,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
  output logic [NPORT-1:0][DATA_W-1:0]  rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NPORT-1:0]  wr_ok;

  // Lower port index has priority on an address clash.
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      wr_ok[i] = we[i];
      for (int j = 0; j < i; j++) begin
        if (we[j] && (addr[j] == addr[i])) wr_ok[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORT; i++) begin
      if (wr_ok[i]) mem[addr[i]] <= wdata[i];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (re[g]) rd_q[g] <= mem[addr[g]];
    end
  end

endmodule

// File: rtl/dpsem_port_out.sv
module dpsem_port_out
  import dpsem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_act_t         act,
  input  logic              flag_val,
  input  logic [DATA_W-1:0] mem_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);

  logic en_d, en_q;
  logic from_mem_d, from_mem_q;
  logic flag_ld, flag_q;

  always_comb begin
    en_d       = (act == ACT_MEM_RD) || (act == ACT_FLG_RD);
    from_mem_d = (act == ACT_MEM_RD);
    flag_ld    = (act == ACT_FLG_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      from_mem_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      en_q       <= en_d;
      from_mem_q <= from_mem_d;
      if (flag_ld) flag_q <= flag_val;
    end
  end

  always_comb begin
    rdata_en = en_q;
    if (!en_q)          rdata = '0;
    else if (from_mem_q) rdata = mem_q;
    else                rdata = {DATA_W{flag_q}};
  end

endmodule

// File: rtl/dpram_semspace.sv
module dpram_semspace
  import dpsem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int FLAG_IW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  lf_addr,
  input  logic [DATA_W-1:0]  lf_wdata,
  input  logic               lf_ce_n,
  input  logic               lf_flag_sel_n,
  input  logic               lf_oe_n,
  input  logic               lf_rd,
  output logic [DATA_W-1:0]  lf_rdata,
  output logic               lf_rdata_en,
  output logic               lf_err,
  output logic               lf_flag_we,
  output logic [FLAG_IW-1:0] lf_flag_idx,
  output logic               lf_flag_wbit,
  input  logic               lf_flag_val,
  input  logic [ADDR_W-1:0]  rt_addr,
  input  logic [DATA_W-1:0]  rt_wdata,
  input  logic               rt_ce_n,
  input  logic               rt_flag_sel_n,
  input  logic               rt_oe_n,
  input  logic               rt_rd,
  output logic [DATA_W-1:0]  rt_rdata,
  output logic               rt_rdata_en,
  output logic               rt_err,
  output logic               rt_flag_we,
  output logic [FLAG_IW-1:0] rt_flag_idx,
  output logic               rt_flag_wbit,
  input  logic               rt_flag_val
);

  localparam int NPORT = 2;

  // Index 0 is the left port, which wins same-address write clashes.
  logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
  logic [NPORT-1:0][DATA_W-1:0]  wdata_v;
  logic [NPORT-1:0]              ce_n_v, sel_n_v, oe_n_v, rd_v, fval_v;
  logic [NPORT-1:0][DATA_W-1:0]  rdata_v, mem_q_v;
  logic [NPORT-1:0]              rdata_en_v, err_v, fwe_v, fwbit_v;
  logic [NPORT-1:0][FLAG_IW-1:0] fidx_v;
  logic [NPORT-1:0]              mem_we_v, mem_re_v;
  port_act_t                     act_v [NPORT];

  assign addr_v  = {rt_addr, lf_addr};
  assign wdata_v = {rt_wdata, lf_wdata};
  assign ce_n_v  = {rt_ce_n, lf_ce_n};
  assign sel_n_v = {rt_flag_sel_n, lf_flag_sel_n};
  assign oe_n_v  = {rt_oe_n, lf_oe_n};
  assign rd_v    = {rt_rd, lf_rd};
  assign fval_v  = {rt_flag_val, lf_flag_val};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpsem_port_ctrl i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n_v[p]),
      .sel_n (sel_n_v[p]),
      .rd    (rd_v[p]),
      .oe_n  (oe_n_v[p]),
      .act   (act_v[p]),
      .err_q (err_v[p])
    );

    always_comb begin
      mem_we_v[p] = (act_v[p] == ACT_MEM_WR);
      mem_re_v[p] = (act_v[p] == ACT_MEM_RD);
      fwe_v[p]    = (act_v[p] == ACT_FLG_WR);
      fidx_v[p]   = addr_v[p][FLAG_IW-1:0];
      fwbit_v[p]  = wdata_v[p][0];
    end

    dpsem_port_out #(.DATA_W(DATA_W)) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_v[p]),
      .flag_val (fval_v[p]),
      .mem_q    (mem_q_v[p]),
      .rdata    (rdata_v[p]),
      .rdata_en (rdata_en_v[p])
    );
  end

  dpsem_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT)) i_mem (
    .clk   (clk),
    .we    (mem_we_v),
    .re    (mem_re_v),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rd_q  (mem_q_v)
  );

  assign lf_rdata     = rdata_v[0];
  assign lf_rdata_en  = rdata_en_v[0];
  assign lf_err       = err_v[0];
  assign lf_flag_we   = fwe_v[0];
  assign lf_flag_idx  = fidx_v[0];
  assign lf_flag_wbit = fwbit_v[0];
  assign rt_rdata     = rdata_v[1];
  assign rt_rdata_en  = rdata_en_v[1];
  assign rt_err       = err_v[1];
  assign rt_flag_we   = fwe_v[1];
  assign rt_flag_idx  = fidx_v[1];
  assign rt_flag_wbit = fwbit_v[1];

endmodule

// File: rtl/dpsem_checks.sv
module dpsem_checks #(
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             ce_n,
  input logic [1:0]             sel_n,
  input logic [1:0]             oe_n,
  input logic [1:0]             rd,
  input logic [1:0][DATA_W-1:0] wdata,
  input logic [1:0]             fval,
  input logic [1:0][DATA_W-1:0] rdata,
  input logic [1:0]             rdata_en,
  input logic [1:0]             err,
  input logic [1:0]             fwe,
  input logic [1:0]             fwbit
);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err[p] |=> err[p]);

    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n[p] && !sel_n[p]) |=> (err[p] && !rdata_en[p]));

    assert_bad_no_flag_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n[p] && !sel_n[p]) |-> !fwe[p]);

    assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n[p] && rd[p]) |=> (!rdata_en[p] && rdata[p] == '0));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n[p] && sel_n[p]) |=> (!rdata_en[p] && rdata[p] == '0));

    assert_flag_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n[p] && !sel_n[p] && rd[p] && !oe_n[p]) |=>
        (rdata_en[p] && rdata[p] == {DATA_W{$past(fval[p])}}));

    assert_flag_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n[p] && !sel_n[p] && !rd[p]) |-> (fwe[p] && fwbit[p] == wdata[p][0]));

    assert_mem_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n[p] && sel_n[p] && !rd[p]) |=> !rdata_en[p]);
  end

endmodule

bind dpram_semspace dpsem_checks #(.DATA_W(DATA_W)) i_dpsem_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     ({rt_ce_n, lf_ce_n}),
  .sel_n    ({rt_flag_sel_n, lf_flag_sel_n}),
  .oe_n     ({rt_oe_n, lf_oe_n}),
  .rd       ({rt_rd, lf_rd}),
  .wdata    ({rt_wdata, lf_wdata}),
  .fval     ({rt_flag_val, lf_flag_val}),
  .rdata    ({rt_rdata, lf_rdata}),
  .rdata_en ({rt_rdata_en, lf_rdata_en}),
  .err      ({rt_err, lf_err}),
  .fwe      ({rt_flag_we, lf_flag_we}),
  .fwbit    ({rt_flag_wbit, lf_flag_wbit})
);

// File: tb/test_dpram_semspace.sv
module test_dpram_semspace;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] addr_s [2];
  logic [7:0]  wdata_s [2];
  logic        ce_n_s [2], sel_n_s [2], oe_n_s [2], rd_s [2], fval_s [2];
  logic [7:0]  rdata_o [2];
  logic        en_o [2], err_o [2], fwe_o [2], fwbit_o [2];
  logic [2:0]  fidx_o [2];

  dpram_semspace i_dpram_semspace (
    .clk(clk), .rst_n(rst_n),
    .lf_addr(addr_s[0]), .lf_wdata(wdata_s[0]), .lf_ce_n(ce_n_s[0]),
    .lf_flag_sel_n(sel_n_s[0]), .lf_oe_n(oe_n_s[0]), .lf_rd(rd_s[0]),
    .lf_rdata(rdata_o[0]), .lf_rdata_en(en_o[0]), .lf_err(err_o[0]),
    .lf_flag_we(fwe_o[0]), .lf_flag_idx(fidx_o[0]), .lf_flag_wbit(fwbit_o[0]),
    .lf_flag_val(fval_s[0]),
    .rt_addr(addr_s[1]), .rt_wdata(wdata_s[1]), .rt_ce_n(ce_n_s[1]),
    .rt_flag_sel_n(sel_n_s[1]), .rt_oe_n(oe_n_s[1]), .rt_rd(rd_s[1]),
    .rt_rdata(rdata_o[1]), .rt_rdata_en(en_o[1]), .rt_err(err_o[1]),
    .rt_flag_we(fwe_o[1]), .rt_flag_idx(fidx_o[1]), .rt_flag_wbit(fwbit_o[1]),
    .rt_flag_val(fval_s[1])
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  logic [7:0] ref_mem [int];
  logic [7:0] exp_data [2];
  logic       exp_en [2], exp_err [2];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic drv(input int p, input logic ce_n, input logic sel_n, input logic rd,
                     input logic oe_n, input logic [11:0] a, input logic [7:0] d,
                     input logic fv);
    ce_n_s[p] = ce_n; sel_n_s[p] = sel_n; rd_s[p] = rd; oe_n_s[p] = oe_n;
    addr_s[p] = a; wdata_s[p] = d; fval_s[p] = fv;
  endtask

  task automatic idle(input int p);
    drv(p, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 8'h00, 1'b0);
  endtask

  // One clock: check same-cycle flag request, model the edge, check outputs.
  task automatic step();
    logic [7:0] wr_val [2];
    logic       wr_do [2];
    #1;
    for (int p = 0; p < 2; p++) begin
      logic e_we;
      e_we = ce_n_s[p] && !sel_n_s[p] && !rd_s[p];
      chk(fwe_o[p] == e_we, $sformatf("flag_we p%0d", p), fwe_o[p], e_we);
      if (e_we) begin
        chk(fidx_o[p] == addr_s[p][2:0], $sformatf("flag_idx p%0d", p), fidx_o[p], addr_s[p][2:0]);
        chk(fwbit_o[p] == wdata_s[p][0], $sformatf("flag_wbit p%0d", p), fwbit_o[p], wdata_s[p][0]);
      end
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      wr_do[p] = 1'b0;
      wr_val[p] = wdata_s[p];
      if (!rst_n) begin
        exp_en[p] = 1'b0; exp_data[p] = 8'h00; exp_err[p] = 1'b0;
      end else begin
        exp_en[p] = 1'b0; exp_data[p] = 8'h00;
        if (!ce_n_s[p] && !sel_n_s[p]) exp_err[p] = 1'b1;
        else if (!ce_n_s[p] && !rd_s[p]) wr_do[p] = 1'b1;
        else if (!ce_n_s[p] && !oe_n_s[p]) begin
          exp_en[p] = 1'b1;
          exp_data[p] = ref_mem.exists(int'(addr_s[p])) ? ref_mem[int'(addr_s[p])] : 8'h00;
        end else if (!sel_n_s[p] && rd_s[p] && !oe_n_s[p]) begin
          exp_en[p] = 1'b1;
          exp_data[p] = {8{fval_s[p]}};
        end
      end
    end
    if (wr_do[1]) ref_mem[int'(addr_s[1])] = wr_val[1];
    if (wr_do[0]) ref_mem[int'(addr_s[0])] = wr_val[0];
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(en_o[p] == exp_en[p], $sformatf("rdata_en p%0d", p), en_o[p], exp_en[p]);
      chk(rdata_o[p] == exp_data[p], $sformatf("rdata p%0d", p), rdata_o[p], exp_data[p]);
      chk(err_o[p] == exp_err[p], $sformatf("err p%0d", p), err_o[p], exp_err[p]);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p); exp_en[p] = 1'b0; exp_err[p] = 1'b0; exp_data[p] = 8'h00;
    end
    cur_req = "R11";
    repeat (3) step();
    rst_n = 1'b1;

    cur_req = "R5";  // writes on both ports, one with output enable low (R2)
    drv(0, 0, 1, 0, 0, 12'h123, 8'hA5, 0);
    drv(1, 0, 1, 0, 1, 12'hFFF, 8'h3C, 0);
    step();
    drv(0, 0, 1, 0, 1, 12'hFF5, 8'h77, 0);
    drv(1, 0, 1, 0, 0, 12'h000, 8'hC3, 0);
    step();

    cur_req = "R2";  // cross reads in one cycle
    drv(0, 0, 1, 1, 0, 12'hFFF, 8'h00, 0);
    drv(1, 0, 1, 1, 0, 12'h123, 8'h00, 0);
    step();

    cur_req = "R4";  // right reads the word the left writes at the same edge
    drv(0, 0, 1, 0, 0, 12'h123, 8'h5A, 0);
    drv(1, 0, 1, 1, 0, 12'h123, 8'h00, 0);
    step();
    cur_req = "R1";
    drv(0, 0, 1, 1, 0, 12'h123, 8'h00, 0);
    drv(1, 0, 1, 1, 0, 12'h000, 8'h00, 0);
    step();

    cur_req = "R10";  // same-address double write
    drv(0, 0, 1, 0, 1, 12'h0AB, 8'h11, 0);
    drv(1, 0, 1, 0, 1, 12'h0AB, 8'h22, 0);
    step();
    drv(0, 0, 1, 1, 0, 12'h0AB, 8'h00, 0);
    drv(1, 0, 1, 1, 0, 12'h0AB, 8'h00, 0);
    step();

    cur_req = "R8";  // reads with output enable high
    drv(0, 0, 1, 1, 1, 12'h0AB, 8'h00, 0);
    drv(1, 1, 0, 1, 1, 12'h003, 8'h00, 1);
    step();

    cur_req = "R3";
    idle(0); idle(1);
    step();

    cur_req = "R6";  // flag writes; memory word 0xFF5 must stay 0x77
    drv(0, 1, 0, 0, 0, 12'hFF5, 8'h00, 0);
    drv(1, 1, 0, 0, 1, 12'h00A, 8'hFF, 0);
    step();
    drv(0, 0, 1, 1, 0, 12'hFF5, 8'h00, 0);
    idle(1);
    step();

    cur_req = "R7";  // flag reads, one of each value
    drv(0, 1, 0, 1, 0, 12'h002, 8'h00, 0);
    drv(1, 1, 0, 1, 0, 12'hF02, 8'h00, 1);
    step();
    drv(0, 1, 0, 1, 0, 12'h007, 8'h00, 1);
    drv(1, 1, 0, 1, 0, 12'h007, 8'h00, 0);
    step();

    cur_req = "R9";  // illegal select on right, legal read on left
    drv(0, 0, 1, 1, 0, 12'hFFF, 8'h00, 0);
    drv(1, 0, 0, 0, 0, 12'h0AB, 8'h99, 0);
    step();
    idle(0); idle(1);
    repeat (2) step();
    drv(1, 0, 1, 1, 0, 12'h0AB, 8'h00, 0);
    step();
    idle(1);
    step();

    cur_req = "R11";  // reset clears the error flag
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule